// File: doc/BRIEF.md
# Signed-Magnitude Shift-Add Multiplier

This block multiplies two signed-magnitude numbers over several clock cycles. Each operand has a sign bit and an unsigned magnitude of `MAG_W` bits. When `start` is pulsed while the unit is idle, it captures both operands. The product sign is fixed at that point as the exclusive-OR of the two operand signs.

The magnitude is then built one multiplier bit per cycle. If the lowest bit of the multiplier register is set, the multiplicand is added into the accumulator, and the carry out is kept. The carry, the accumulator and the multiplier register then shift right together by one place. A down-counter preset to `MAG_W` stops the run after `MAG_W` iterations. The double-width magnitude is read as `prod_hi` (upper half) next to `prod_lo` (lower half), and a one-cycle `done` strobe marks completion. The result stays on the outputs until the next accepted start.

Top module: `sm_shift_mult`

## Requirements
- R1: After reset, `busy` and `done` are 0, and `prod_hi`, `prod_lo` and `prod_sign` are 0.
- R2: A `start` sampled high while `busy` is 0 captures both operands. `busy` is 1 from the next cycle on.
- R3: `prod_sign` equals `mcand_sign` XOR `mplier_sign` of the captured operands, even when a magnitude is zero.
- R4: On completion, {`prod_hi`,`prod_lo`} equals the unsigned product of the two captured magnitudes. `prod_hi` holds the upper `MAG_W` bits.
- R5: `done` goes high for exactly one cycle, `MAG_W` clock edges after the edge that accepted `start`. In that same cycle `busy` drops to 0.
- R6: A `start` pulse while `busy` is 1 is ignored. The run is neither restarted nor lengthened, and its result is unchanged.
- R7: Operand inputs that change after the start edge have no effect on the result. The captured multiplicand stays constant for the whole run.
- R8: After `done`, the product outputs hold their values until the next accepted start.
- R9: The iteration counter starts at `MAG_W`. It drops by exactly one per busy cycle and is never zero while busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a multiplication (honoured only when idle) |
| mcand_sign | input | 1 | Multiplicand sign (1 = negative) |
| mcand_mag | input | MAG_W | Multiplicand magnitude |
| mplier_sign | input | 1 | Multiplier sign (1 = negative) |
| mplier_mag | input | MAG_W | Multiplier magnitude |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle completion strobe |
| prod_sign | output | 1 | Product sign |
| prod_hi | output | MAG_W | Upper half of product magnitude |
| prod_lo | output | MAG_W | Lower half of product magnitude |

## Verification
The in-RTL assertions cover three things on every cycle:
- the counter's strict countdown and the fact that it is never zero while busy;
- the one-cycle width of `done` and its exclusion with `busy`;
- the stability of the captured multiplicand and the product sign during a run.

The arithmetic result needs the bench's directed scenarios. These cover every sign combination, zero and all-ones magnitudes, and a multiplier of one, all compared against a product computed in the bench. The scenarios also measure the exact latency to `done`. They disturb the inputs and pulse `start` mid-run to show that both are ignored, and they show that the result holds after completion.

// File: rtl/sm_shift_mult.sv
module sm_shift_mult #(
  parameter int MAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mcand_sign,
  input  logic [MAG_W-1:0] mcand_mag,
  input  logic             mplier_sign,
  input  logic [MAG_W-1:0] mplier_mag,
  output logic             busy,
  output logic             done,
  output logic             prod_sign,
  output logic [MAG_W-1:0] prod_hi,
  output logic [MAG_W-1:0] prod_lo
);
  localparam int CNT_W = $clog2(MAG_W + 1);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(MAG_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

  logic [MAG_W-1:0] b_reg, acc, q_reg;
  logic [CNT_W-1:0] cnt;
  logic             sgn;
  logic [MAG_W:0]   sum;

  assign sum = q_reg[0] ? ({1'b0, acc} + {1'b0, b_reg}) : {1'b0, acc};

  assign prod_sign = sgn;
  assign prod_hi   = acc;
  assign prod_lo   = q_reg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_reg <= '0;
      acc   <= '0;
      q_reg <= '0;
      cnt   <= '0;
      sgn   <= 1'b0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          b_reg <= mcand_mag;
          q_reg <= mplier_mag;
          sgn   <= mcand_sign ^ mplier_sign;
          acc   <= '0;
          cnt   <= CNT_INIT;
          busy  <= 1'b1;
        end
      end else begin
        acc   <= sum[MAG_W:1];
        q_reg <= {sum[0], q_reg[MAG_W-1:1]};
        cnt   <= cnt - CNT_W'(1);
        if (cnt == CNT_LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R9: counter bounds and strict countdown
  assert_cnt_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt != '0 && cnt <= CNT_INIT));
  assert_cnt_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != CNT_LAST) |=> (busy && cnt == $past(cnt) - CNT_W'(1)));
  assert_cnt_preset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && cnt == CNT_INIT));
  // R5: done is a single-cycle strobe, exclusive with busy
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R6/R7: run state is not disturbed by start or inputs while busy
  assert_mcand_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(b_reg));
  assert_sign_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(sgn));
  // R8: result held while idle without start
  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(acc) && $stable(q_reg) && $stable(sgn)));
endmodule

// File: tb/sm_shift_mult_test.sv
module sm_shift_mult_test;
  localparam int MAG_W = 8;
  localparam time CLK_PERIOD = 10ns;
  localparam int MAXV = (1 << MAG_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic mcand_sign = 1'b0, mplier_sign = 1'b0;
  logic [MAG_W-1:0] mcand_mag = '0, mplier_mag = '0;
  logic busy, done, prod_sign;
  logic [MAG_W-1:0] prod_hi, prod_lo;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sm_shift_mult #(.MAG_W(MAG_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mcand_sign(mcand_sign), .mcand_mag(mcand_mag),
    .mplier_sign(mplier_sign), .mplier_mag(mplier_mag),
    .busy(busy), .done(done), .prod_sign(prod_sign),
    .prod_hi(prod_hi), .prod_lo(prod_lo));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Launches one multiply; optionally disturbs inputs and pulses start mid-run.
  task automatic run_op(input bit bs, input int b, input bit qs, input int q, input bit disturb);
    int cyc = 0;
    longint expv = longint'(b) * longint'(q);
    @(negedge clk);
    mcand_sign = bs; mcand_mag = MAG_W'(b);
    mplier_sign = qs; mplier_mag = MAG_W'(q);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R2 busy after start", longint'(busy), 1);
    while (done !== 1'b1 && cyc < 4 * MAG_W) begin
      if (disturb && cyc == 2) begin
        mcand_sign = ~bs; mcand_mag = ~MAG_W'(b);
        mplier_sign = ~qs; mplier_mag = ~MAG_W'(q);
        start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(cyc == MAG_W, disturb ? "R6 latency with mid-run start" : "R5 latency", cyc, MAG_W);
    chk(busy === 1'b0, "R5 busy low at done", longint'(busy), 0);
    chk(prod_sign === (bs ^ qs), "R3 sign", longint'(prod_sign), longint'(bs ^ qs));
    chk({prod_hi, prod_lo} === (2*MAG_W)'(expv),
        disturb ? "R7 product with disturbed inputs" : "R4 product",
        longint'({prod_hi, prod_lo}), expv);
    @(negedge clk);
    chk(done === 1'b0, "R5 done single cycle", longint'(done), 0);
  endtask

  task automatic test_reset();
    chk(busy === 1'b0 && done === 1'b0, "R1 control idle", longint'({busy, done}), 0);
    chk({prod_sign, prod_hi, prod_lo} === '0, "R1 outputs zero",
        longint'({prod_sign, prod_hi, prod_lo}), 0);
  endtask

  task automatic test_signs();
    for (int s = 0; s < 4; s++) run_op(s[1], 13, s[0], 11, 1'b0);
  endtask

  task automatic test_corners();
    run_op(1'b0, 0, 1'b1, 77, 1'b0);
    run_op(1'b1, 200, 1'b0, 0, 1'b0);
    run_op(1'b1, MAXV, 1'b1, MAXV, 1'b0);
    run_op(1'b0, 173, 1'b1, 1, 1'b0);
    run_op(1'b1, 1, 1'b0, MAXV, 1'b0);
  endtask

  task automatic test_busy_ignore();
    run_op(1'b1, 91, 1'b0, 57, 1'b1);
  endtask

  task automatic test_hold();
    logic [2*MAG_W:0] snap;
    run_op(1'b0, 45, 1'b1, 99, 1'b0);
    snap = {prod_sign, prod_hi, prod_lo};
    mcand_mag = '1; mplier_mag = '1; mcand_sign = 1'b1; mplier_sign = 1'b1;
    repeat (5) @(negedge clk);
    chk({prod_sign, prod_hi, prod_lo} === snap, "R8 result held",
        longint'({prod_sign, prod_hi, prod_lo}), longint'(snap));
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_signs();
        test_corners();
        test_busy_ignore();
        test_hold();
      end
      begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule